// File: doc/BRIEF.md
# Doorbell Command Mailbox

This block is a memory-mapped mailbox through which a host hands commands to a command engine on the device side. The host side is a little-endian register port. Each access is 1, 2, 4 or 8 bytes wide, and its address is aligned to that width. The block holds a capability word, a control word carrying the doorbell, a command word, a mailbox status word and a background-status word. A payload buffer of `2^PL_LOG2` bytes follows these registers.

The host fills the payload and the command word, then sets the doorbell. The block latches the command-set byte, command byte and input length. It then sweeps the payload one byte per cycle: each byte is copied into a private input buffer and the live byte is cleared. After the sweep it raises a valid strobe toward the backend. The backend reads its input from the private copy and may write result bytes into the payload. It then pulses done together with a return code, an output length and a background-started flag. On that pulse the block rebuilds the status and command words from the results and clears the doorbell.

The background-status inputs are sampled into their register by a full-width read. The busy bit of the status word is refreshed from percent-complete and the abort flag on a full-width status read.

Top module: `mbox_regblk`

## Requirements
- R1: After reset the capability word at 0x00 reads 0x000001CB and the control, command and status words read zero. The capability fields are: payload-size exponent in bits 3:0 (PL_LOG2 = 11), background-interrupt-capable in bit 6, message number in bits 10:7 (MSG_NUM = 3), ready time in bits 18:11 = 0, and type in bits 20:19 = 0.
- R2: Writes at byte offsets 0x20 and above land in the payload byte lanes selected by size and address. Byte lane k of `host_wdata` holds the byte at address (word base + k). Such writes never start a command.
- R3: The capability word (0x00) and control word (0x04) accept only 4-byte writes. The command word (0x08) and background-status word (0x18) accept only 8-byte writes. Writes of any other size to these locations leave them unchanged.
- R4: Host writes to the status word at 0x10 never change it.
- R5: After any register write (offset below 0x20), if the control doorbell bit 0 is set and no command is in flight, the block launches a command. It presents command bits 7:0 as the command byte, bits 15:8 as the command set and bits 36:16 as the input length.
- R6: Before `bk_valid` rises, the payload is cleared one byte per cycle. `bk_valid` is first seen 2^PL_LOG2 + 1 clock edges after the edge that accepted the doorbell write. The backend read port returns the pre-clear payload bytes.
- R7: On completion the status word becomes: bit 0 = backend background-started flag, bits 47:32 = backend return code, all other bits 0.
- R8: On completion the command word keeps the latched command and command-set bytes, its bits 36:16 become the output length, and the doorbell bit 0 of the control word clears.
- R9: An 8-byte read at 0x18 returns the current background opcode in bits 15:0, percent-complete in bits 22:16 and the background return code in bits 47:32, and stores that value. Narrower reads return the last stored value.
- R10: An 8-byte read at 0x10 sets status bit 0 to 1 unless percent-complete equals 100 or the abort flag is set. The refreshed value is both returned and stored.
- R11: While a command is in flight, host writes to the control and command words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (drives read side effects) |
| host_addr | input | PL_LOG2+1 | Byte address |
| host_size | input | 2 | Access size: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| host_wdata | input | 64 | Write data, lane-aligned to the 8-byte word |
| host_rdata | output | 64 | Read data of the addressed 8-byte word |
| bk_valid | output | 1 | Command presented to backend |
| bk_cmd_set | output | 8 | Latched command set |
| bk_cmd_code | output | 8 | Latched command byte |
| bk_len_in | output | 21 | Latched input length |
| bk_raddr | input | PL_LOG2 | Input-copy read address |
| bk_rdata | output | 8 | Input-copy read data |
| bk_we | input | 1 | Backend payload byte write |
| bk_waddr | input | PL_LOG2 | Backend payload write address |
| bk_wdata | input | 8 | Backend payload write data |
| bk_done | input | 1 | Backend completion pulse |
| bk_rc | input | 16 | Backend return code |
| bk_len_out | input | 21 | Backend output length |
| bk_bg_started | input | 1 | Backend started a background operation |
| bg_opcode | input | 16 | Current background opcode |
| bg_pct | input | 7 | Background percent-complete |
| bg_rc | input | 16 | Background return code |
| bg_aborted | input | 1 | Background operation aborted |

## Verification
The hardest condition to reach from the ports is a host write arriving while a command is in flight. Between the doorbell and completion the sweep alone takes thousands of cycles. The bench therefore holds its backend model after `bk_valid` rises and writes a new command word and a cleared control word. It reads both back before it pulses done. The sweep length is checked by counting falling edges from the doorbell write to the first visible `bk_valid`. The clear-versus-copy split is checked by reading the same bytes through the backend port and the host port.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CLEAR = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  localparam int OFS_CAP  = 'h00;
  localparam int OFS_CTRL = 'h04;
  localparam int OFS_CMD  = 'h08;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_BGS  = 'h18;
  localparam int OFS_PL   = 'h20;

  localparam int LEN_W = 21;
  localparam int RC_W  = 16;
endpackage

// File: rtl/mbox_host_dec.sv
module mbox_host_dec
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  output logic [7:0]        lane_en,
  output logic              pl_sel,
  output logic              wr_cap,
  output logic              wr_ctrl,
  output logic              wr_cmd,
  output logic              wr_bgs,
  output logic              reg_wr,
  output logic              rd_stat64,
  output logic              rd_bgs64
);
  acc_size_e sz;
  logic      is_w, is_d;

  always_comb begin
    sz = acc_size_e'(host_size);
    is_w = (sz == SZ_WORD);
    is_d = (sz == SZ_DBL);
    unique case (sz)
      SZ_BYTE: lane_en = 8'h01 << host_addr[2:0];
      SZ_HALF: lane_en = 8'h03 << {host_addr[2:1], 1'b0};
      SZ_WORD: lane_en = 8'h0F << {host_addr[2], 2'b00};
      default: lane_en = 8'hFF;
    endcase
    pl_sel    = (int'(host_addr) >= OFS_PL);
    wr_cap    = host_wr && (int'(host_addr) == OFS_CAP)  && is_w;
    wr_ctrl   = host_wr && (int'(host_addr) == OFS_CTRL) && is_w;
    wr_cmd    = host_wr && (int'(host_addr) == OFS_CMD)  && is_d;
    wr_bgs    = host_wr && (int'(host_addr) == OFS_BGS)  && is_d;
    reg_wr    = host_wr && !pl_sel;
    rd_stat64 = host_rd && (int'(host_addr) == OFS_STAT) && is_d;
    rd_bgs64  = host_rd && (int'(host_addr) == OFS_BGS)  && is_d;
  end
endmodule

// File: rtl/mbox_payload.sv
module mbox_payload #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [IDX_W-4:0] host_word,
  input  logic [7:0]       lane_en,
  input  logic [63:0]      wdata,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             bk_we,
  input  logic [IDX_W-1:0] bk_waddr,
  input  logic [7:0]       bk_wdata,
  input  logic [IDX_W-4:0] rd_word,
  output logic [63:0]      rd_data,
  input  logic [IDX_W-1:0] bk_raddr,
  output logic [7:0]       bk_rdata
);
  localparam int NBYTES = 1 << IDX_W;

  logic [7:0] live_q [NBYTES];
  logic [7:0] copy_q [NBYTES];

  // Sweep has priority: while it runs every other writer is shut out.
  always_ff @(posedge clk) begin
    if (clr_en) begin
      copy_q[clr_idx] <= live_q[clr_idx];
      live_q[clr_idx] <= 8'h00;
    end else begin
      if (host_we) begin
        for (int l = 0; l < 8; l++) begin
          if (lane_en[l]) live_q[{host_word, 3'(l)}] <= wdata[8*l +: 8];
        end
      end
      if (bk_we) live_q[bk_waddr] <= bk_wdata;
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_lane
    assign rd_data[8*g +: 8] = live_q[{rd_word, 3'(g)}];
  end

  assign bk_rdata = copy_q[bk_raddr];
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             done,
  output logic             busy,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             run,
  output logic             launch,
  output logic             finish
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (trig) begin
          state_d = SEQ_CLEAR;
          idx_d   = '0;
        end
      end
      SEQ_CLEAR: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == '1) state_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (done) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy    = (state_q != SEQ_IDLE);
  assign clr_en  = (state_q == SEQ_CLEAR);
  assign clr_idx = idx_q;
  assign run     = (state_q == SEQ_RUN);
  assign launch  = (state_q == SEQ_IDLE) && trig;
  assign finish  = (state_q == SEQ_RUN) && done;
endmodule

// File: rtl/mbox_regblk.sv
module mbox_regblk
  import mbox_pkg::*;
#(
  parameter  int PL_LOG2 = 11,
  parameter  int MSG_NUM = 3,
  localparam int IDX_W   = PL_LOG2,
  localparam int ADDR_W  = PL_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              bk_valid,
  output logic [7:0]        bk_cmd_set,
  output logic [7:0]        bk_cmd_code,
  output logic [20:0]       bk_len_in,
  input  logic [IDX_W-1:0]  bk_raddr,
  output logic [7:0]        bk_rdata,
  input  logic              bk_we,
  input  logic [IDX_W-1:0]  bk_waddr,
  input  logic [7:0]        bk_wdata,
  input  logic              bk_done,
  input  logic [15:0]       bk_rc,
  input  logic [20:0]       bk_len_out,
  input  logic              bk_bg_started,
  input  logic [15:0]       bg_opcode,
  input  logic [6:0]        bg_pct,
  input  logic [15:0]       bg_rc,
  input  logic              bg_aborted
);
  localparam int        WORD_W  = IDX_W - 3;
  localparam int        PL_WORD = OFS_PL / 8;
  localparam logic [31:0] CAP_RST = {11'h0, 2'b00, 8'h00, 4'(MSG_NUM), 1'b1, 2'b00, 4'(PL_LOG2)};

  // ---------------- decode ----------------
  logic [7:0] lane_en;
  logic       pl_sel, wr_cap, wr_ctrl, wr_cmd, wr_bgs, reg_wr, rd_stat64, rd_bgs64;

  mbox_host_dec #(.ADDR_W(ADDR_W)) u_dec (
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .host_addr(host_addr),
    .host_size(host_size),
    .lane_en  (lane_en),
    .pl_sel   (pl_sel),
    .wr_cap   (wr_cap),
    .wr_ctrl  (wr_ctrl),
    .wr_cmd   (wr_cmd),
    .wr_bgs   (wr_bgs),
    .reg_wr   (reg_wr),
    .rd_stat64(rd_stat64),
    .rd_bgs64 (rd_bgs64)
  );

  logic [WORD_W-1:0] pl_word;
  assign pl_word = host_addr[IDX_W-1:3] - WORD_W'(PL_WORD);

  // ---------------- sequencer ----------------
  logic [31:0] cap_q, cap_d;
  logic [31:0] ctrl_q, ctrl_d;
  logic [63:0] cmd_q, cmd_d;
  logic [63:0] stat_q, stat_d;
  logic [63:0] bgs_q, bgs_d;
  logic        reg_wr_q;
  logic [7:0]  set_q, set_d, code_q, code_d;
  logic [LEN_W-1:0] len_q, len_d;

  logic             busy, clr_en, run, launch, finish;
  logic [IDX_W-1:0] clr_idx;

  mbox_seq #(.IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (reg_wr_q && ctrl_q[0]),
    .done   (bk_done),
    .busy   (busy),
    .clr_en (clr_en),
    .clr_idx(clr_idx),
    .run    (run),
    .launch (launch),
    .finish (finish)
  );

  // ---------------- payload ----------------
  logic [63:0] pl_rdata;

  mbox_payload #(.IDX_W(IDX_W)) u_pl (
    .clk      (clk),
    .host_we  (host_wr && pl_sel),
    .host_word(pl_word),
    .lane_en  (lane_en),
    .wdata    (host_wdata),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .bk_we    (bk_we && run),
    .bk_waddr (bk_waddr),
    .bk_wdata (bk_wdata),
    .rd_word  (pl_word),
    .rd_data  (pl_rdata),
    .bk_raddr (bk_raddr),
    .bk_rdata (bk_rdata)
  );

  // ---------------- live views ----------------
  logic        bg_live;
  logic [63:0] bgs_live;
  assign bg_live  = !((bg_pct == 7'd100) || bg_aborted);
  assign bgs_live = {16'h0, bg_rc, 9'h0, bg_pct, bg_opcode};

  // ---------------- next state ----------------
  always_comb begin
    cap_d  = cap_q;
    ctrl_d = ctrl_q;
    cmd_d  = cmd_q;
    stat_d = stat_q;
    bgs_d  = bgs_q;
    set_d  = set_q;
    code_d = code_q;
    len_d  = len_q;

    if (wr_cap)            cap_d  = host_wdata[31:0];
    if (wr_ctrl && !busy)  ctrl_d = host_wdata[63:32];
    if (wr_cmd && !busy)   cmd_d  = host_wdata;
    if (wr_bgs)            bgs_d  = host_wdata;
    else if (rd_bgs64)     bgs_d  = bgs_live;
    if (rd_stat64)         stat_d = {stat_q[63:1], bg_live};

    if (launch) begin
      code_d = cmd_q[7:0];
      set_d  = cmd_q[15:8];
      len_d  = cmd_q[36:16];
    end

    if (finish) begin
      stat_d    = {16'h0, bk_rc, 31'h0, bk_bg_started};
      cmd_d     = {27'h0, bk_len_out, set_q, code_q};
      ctrl_d[0] = 1'b0;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= CAP_RST;
      ctrl_q   <= '0;
      cmd_q    <= '0;
      stat_q   <= '0;
      bgs_q    <= '0;
      reg_wr_q <= 1'b0;
      set_q    <= '0;
      code_q   <= '0;
      len_q    <= '0;
    end else begin
      cap_q    <= cap_d;
      ctrl_q   <= ctrl_d;
      cmd_q    <= cmd_d;
      stat_q   <= stat_d;
      bgs_q    <= bgs_d;
      reg_wr_q <= reg_wr;
      set_q    <= set_d;
      code_q   <= code_d;
      len_q    <= len_d;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    if (pl_sel) begin
      host_rdata = pl_rdata;
    end else begin
      unique case (host_addr[4:3])
        2'd0: host_rdata = {ctrl_q, cap_q};
        2'd1: host_rdata = cmd_q;
        2'd2: host_rdata = (host_size == 2'd3) ? {stat_q[63:1], bg_live} : stat_q;
        default: host_rdata = (host_size == 2'd3) ? bgs_live : bgs_q;
      endcase
    end
  end

  assign bk_valid    = run;
  assign bk_cmd_set  = set_q;
  assign bk_cmd_code = code_q;
  assign bk_len_in   = len_q;
endmodule

// File: rtl/mbox_regblk_chk.sv
module mbox_regblk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic [2:0]  addr_lo,
  input logic [1:0]  host_size,
  input logic        bk_valid,
  input logic        bk_done,
  input logic        busy,
  input logic        wr_cmd,
  input logic        clearing,
  input logic        ctrl_db,
  input logic [63:0] cmd_q,
  input logic [63:0] stat_q,
  input logic        rd_stat64
);
  logic [2:0] align_mask;
  always_comb begin
    unique case (host_size)
      2'd0: align_mask = 3'b000;
      2'd1: align_mask = 3'b001;
      2'd2: align_mask = 3'b011;
      default: align_mask = 3'b111;
    endcase
  end

  // R2
  aligned_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr || host_rd) |-> ((addr_lo & align_mask) == 3'b000));

  // R4
  stat_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> ($past(bk_valid && bk_done) || $past(rd_stat64)));

  // R5
  launch_needs_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bk_valid) |-> (ctrl_db && $past(clearing)));

  // R8
  done_clears_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_valid && bk_done) |=> (!ctrl_db && !bk_valid));

  // R11
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd && !(bk_valid && bk_done)) |=> $stable(cmd_q));

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_valid && !bk_done) |=> bk_valid);
endmodule

bind mbox_regblk mbox_regblk_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_wr  (host_wr),
  .host_rd  (host_rd),
  .addr_lo  (host_addr[2:0]),
  .host_size(host_size),
  .bk_valid (bk_valid),
  .bk_done  (bk_done),
  .busy     (busy),
  .wr_cmd   (wr_cmd),
  .clearing (clr_en),
  .ctrl_db  (ctrl_q[0]),
  .cmd_q    (cmd_q),
  .stat_q   (stat_q),
  .rd_stat64(rd_stat64)
);

// File: tb/mbox_regblk_bench.sv
`timescale 1ns/1ps
module mbox_regblk_bench;
  localparam int PL_LOG2 = 11;
  localparam int NB      = 1 << PL_LOG2;

  logic        clk, rst_n;
  logic        host_wr, host_rd;
  logic [11:0] host_addr;
  logic [1:0]  host_size;
  logic [63:0] host_wdata, host_rdata;
  logic        bk_valid;
  logic [7:0]  bk_cmd_set, bk_cmd_code;
  logic [20:0] bk_len_in;
  logic [10:0] bk_raddr, bk_waddr;
  logic [7:0]  bk_rdata, bk_wdata;
  logic        bk_we, bk_done, bk_bg_started;
  logic [15:0] bk_rc;
  logic [20:0] bk_len_out;
  logic [15:0] bg_opcode, bg_rc;
  logic [6:0]  bg_pct;
  logic        bg_aborted;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  mbox_regblk #(.PL_LOG2(PL_LOG2), .MSG_NUM(3)) u_mbox_regblk (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] a, input logic [1:0] sz, input logic [63:0] d);
    host_wr = 1'b1; host_addr = a; host_size = sz; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, input logic [1:0] sz, output logic [63:0] d);
    host_rd = 1'b1; host_addr = a; host_size = sz;
    #2 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_valid(output int cnt);
    cnt = 0;
    while (!bk_valid && cnt < NB + 20) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic bk_finish(input logic [15:0] rc, input logic [20:0] lo, input logic bg);
    bk_rc = rc; bk_len_out = lo; bk_bg_started = bg; bk_done = 1'b1;
    @(negedge clk);
    bk_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    host_read(12'h000, 2'd2, d);
    check("R1 cap", {32'h0, d[31:0]}, 64'h1CB);
    check("R1 ctrl", {32'h0, d[63:32]}, 64'h0);
    host_read(12'h008, 2'd3, d);
    check("R1 cmd", d, 64'h0);
    host_read(12'h010, 2'd2, d);
    check("R1 stat", d, 64'h0);
  endtask

  task automatic t_payload();
    logic [63:0] d;
    host_write(12'h020, 2'd3, 64'h0807060504030201);
    host_write(12'h029, 2'd0, 64'h000000000000AA00);
    host_write(12'h02A, 2'd1, 64'h00000000CCBB0000);
    host_write(12'h02C, 2'd2, 64'h44332211_00000000);
    host_write(12'h028, 2'd0, 64'h00000000000000EE);
    host_read(12'h020, 2'd3, d);
    check("R2 pl word0", d, 64'h0807060504030201);
    host_read(12'h028, 2'd3, d);
    check("R2 pl word1 lanes", d, 64'h44332211CCBBAAEE);
    repeat (3) @(negedge clk);
    check("R2 no launch", {63'h0, bk_valid}, 64'h0);
  endtask

  task automatic t_size();
    logic [63:0] d;
    host_write(12'h008, 2'd2, 64'h0000_0000_FFFF_FFFF);
    host_read(12'h008, 2'd3, d);
    check("R3 cmd 4B dropped", d, 64'h0);
    host_write(12'h000, 2'd3, 64'h0);
    host_read(12'h000, 2'd2, d);
    check("R3 cap 8B dropped", {32'h0, d[31:0]}, 64'h1CB);
    host_write(12'h004, 2'd1, 64'h0000_0001_0000_0000);
    host_read(12'h004, 2'd2, d);
    check("R3 ctrl 2B dropped", {32'h0, d[63:32]}, 64'h0);
    repeat (3) @(negedge clk);
    check("R3 no launch", {63'h0, bk_valid}, 64'h0);
    host_write(12'h018, 2'd3, 64'h0000_ABCD_0000_1234);
    host_read(12'h018, 2'd2, d);
    check("R3 bgs 8B taken", d, 64'h0000_ABCD_0000_1234);
  endtask

  task automatic t_stat_wr();
    logic [63:0] d;
    host_write(12'h010, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    host_write(12'h010, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    host_read(12'h010, 2'd2, d);
    check("R4 stat write ignored", d, 64'h0);
  endtask

  task automatic t_bg();
    logic [63:0] d;
    bg_opcode = 16'hBEEF; bg_pct = 7'd42; bg_rc = 16'h0055; bg_aborted = 1'b0;
    host_read(12'h018, 2'd3, d);
    check("R9 bgs live", d, 64'h0000_0055_002A_BEEF);
    bg_opcode = 16'h1111; bg_pct = 7'd7;
    host_read(12'h018, 2'd2, d);
    check("R9 bgs stored", d, 64'h0000_0055_002A_BEEF);
    host_read(12'h010, 2'd3, d);
    check("R10 busy live", d, 64'h1);
    host_read(12'h010, 2'd2, d);
    check("R10 busy stored", d, 64'h1);
    bg_pct = 7'd100;
    host_read(12'h010, 2'd3, d);
    check("R10 pct100", d, 64'h0);
    bg_pct = 7'd50; bg_aborted = 1'b1;
    host_read(12'h010, 2'd3, d);
    check("R10 aborted", d, 64'h0);
    bg_pct = 7'd100; bg_aborted = 1'b0;
  endtask

  task automatic t_cmd1();
    logic [63:0] d;
    int cnt;
    host_write(12'h020, 2'd3, 64'h7766554433221100);
    host_write(12'h008, 2'd3, 64'h0000_0000_0008_4207);
    host_write(12'h004, 2'd2, 64'h0000_0001_0000_0000);
    wait_valid(cnt);
    check("R6 sweep cycles", 64'(cnt), 64'(NB + 1));
    check("R5 cmd byte", {56'h0, bk_cmd_code}, 64'h07);
    check("R5 cmd set", {56'h0, bk_cmd_set}, 64'h42);
    check("R5 len in", {43'h0, bk_len_in}, 64'h8);
    for (int i = 0; i < 8; i++) begin
      bk_raddr = 11'(i);
      #1 check("R6 input copy", {56'h0, bk_rdata}, 64'(8'h11 * i));
    end
    host_read(12'h020, 2'd3, d);
    check("R6 payload cleared", d, 64'h0);
    bk_we = 1'b1; bk_waddr = 11'd0; bk_wdata = 8'hA5;
    @(negedge clk);
    bk_we = 1'b0;
    bk_finish(16'h0000, 21'd1, 1'b1);
    host_read(12'h010, 2'd2, d);
    check("R7 stat bg", d, 64'h1);
    host_read(12'h008, 2'd3, d);
    check("R8 cmd rebuilt", d, 64'h0000_0000_0001_4207);
    host_read(12'h004, 2'd2, d);
    check("R8 doorbell clear", {63'h0, d[32]}, 64'h0);
    host_read(12'h020, 2'd3, d);
    check("R6 result byte", d, 64'h0000_0000_0000_00A5);
    host_read(12'h028, 2'd3, d);
    check("R6 stale gone", d, 64'h0);
  endtask

  task automatic t_cmd2_busy();
    logic [63:0] d;
    int cnt;
    host_write(12'h008, 2'd3, 64'h0000_0000_0000_1122);
    host_write(12'h004, 2'd2, 64'h0000_0001_0000_0000);
    wait_valid(cnt);
    check("R5 second launch", {63'h0, bk_valid}, 64'h1);
    host_write(12'h008, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    host_write(12'h004, 2'd2, 64'h0);
    host_read(12'h008, 2'd3, d);
    check("R11 cmd held", d, 64'h0000_0000_0000_1122);
    host_read(12'h004, 2'd2, d);
    check("R11 ctrl held", {63'h0, d[32]}, 64'h1);
    bk_finish(16'h1234, 21'h10, 1'b0);
    host_read(12'h010, 2'd2, d);
    check("R7 stat rc", d, 64'h0000_1234_0000_0000);
    host_read(12'h008, 2'd3, d);
    check("R8 cmd len out", d, 64'h0000_0000_0010_1122);
  endtask

  initial begin
    host_wr = 0; host_rd = 0; host_addr = '0; host_size = '0; host_wdata = '0;
    bk_raddr = '0; bk_we = 0; bk_waddr = '0; bk_wdata = '0; bk_done = 0;
    bk_rc = '0; bk_len_out = '0; bk_bg_started = 0;
    bg_opcode = '0; bg_pct = 7'd100; bg_rc = '0; bg_aborted = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_payload();
    t_size();
    t_stat_wr();
    t_bg();
    t_cmd1();
    t_cmd2_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule